// File: doc/BRIEF.md
# Duplicated-Unit Compare and Checkpoint Recovery Controller

Two copies of an execution unit run the same instruction stream. Each cycle both copies present a destination register index, a destination register value and an instruction address. The controller compares the two copies in the stage before retirement. The compare runs alongside normal execution, so a stream that matches never stalls. When the copies agree, the retire stage writes the register value into a protected checkpoint file and records the instruction address as the last good point.

When the copies disagree, the controller stops accepting work and runs a fixed recovery sequence:

1. It holds the execution units in reset. The checkpoint file is not reset.
2. It asks the cache to flush its data and tags, and waits for a completion handshake.
3. It replays the checkpoint file to the units, one entry per cycle.
4. It issues a retry from the last good address.

A saturating error counter sorts the faults into classes. An error that arrives after a long clean run is treated as transient. Errors that repeat are treated as intermittent. Once the count reaches the threshold the fault is treated as permanent, and the controller requests that a spare processor be brought in. A sticky class register records every class seen, and software clears it one bit at a time.

Top module: `lockstep_retry_ctrl`

## Requirements
- R1: When `inValid` is high and the two copies differ in index, value or address while the block is idle, `busy` is high from the next cycle. A matching stream never raises `busy`.
- R2: A matching instruction accepted at edge k is retired at edge k+1. After that edge `ckptAddr` shows its address and the checkpoint entry for its index holds its value.
- R3: The checkpoint is not written in a cycle in which a mismatch is detected, even when an older matching instruction is waiting in the retire stage. That older instruction is dropped.
- R4: While `busy` is high, all duplicated inputs are ignored. A mismatch seen then changes neither the checkpoint, nor the error count, nor `faultStatus`.
- R5: Recovery holds `unitReset` high for RESET_CYC cycles. It then holds `purgeReq` high until `purgeDone` is sampled high.
- R6: After the purge, `restoreValid` is high for NREG cycles. `restoreIdx` steps 0, 1, …, NREG-1 and `restoreData` carries the stored value of that entry.
- R7: After the restore, `retryValid` is high for exactly one cycle with `retryAddr` equal to `ckptAddr`. The block is idle on the following cycle.
- R8: Each accepted mismatch raises the error count by one, and the count saturates at ERR_THRESH (default 4). The count returns to zero after CLEAN_RUN (default 6) checkpoint writes in a row with no accepted mismatch, and any accepted mismatch restarts that run.
- R9: On an accepted mismatch, `faultStatus` sets one bit from the new count n. Bit 0 (transient) is set if n = 1. Bit 1 (intermittent) is set if 1 < n < ERR_THRESH. Bit 2 (permanent) is set if n = ERR_THRESH. The bits are sticky, and all zero means no fault.
- R10: `spareReq` is high exactly while the permanent bit of `faultStatus` is set.
- R11: A cycle with `clrStb` high clears the `faultStatus` bits set in `clrMask`. A class bit set in the same cycle stays set.
- R12: After reset the block is idle, every output is zero and every checkpoint entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Both copies present an instruction this cycle |
| aIdx | input | IDX_W | Copy A destination register index |
| aData | input | DATA_W | Copy A destination register value |
| aAddr | input | ADDR_W | Copy A instruction address |
| bIdx | input | IDX_W | Copy B destination register index |
| bData | input | DATA_W | Copy B destination register value |
| bAddr | input | ADDR_W | Copy B instruction address |
| purgeDone | input | 1 | Cache flush of data and tags has finished |
| clrStb | input | 1 | Write-one-to-clear strobe for `faultStatus` |
| clrMask | input | 3 | Bits of `faultStatus` to clear |
| busy | output | 1 | Recovery in progress |
| unitReset | output | 1 | Reset to both execution units |
| purgeReq | output | 1 | Cache flush request |
| restoreValid | output | 1 | Checkpoint replay beat |
| restoreIdx | output | IDX_W | Register index being replayed |
| restoreData | output | DATA_W | Register value being replayed |
| retryValid | output | 1 | Restart request |
| retryAddr | output | ADDR_W | Restart address |
| ckptAddr | output | ADDR_W | Address of the last checkpointed instruction |
| faultStatus | output | 3 | Sticky classes: bit 0 transient, bit 1 intermittent, bit 2 permanent |
| spareReq | output | 1 | Request to activate a spare processor |

## Verification
The compare is tried with three corruptions: one on the value, one on the index and one on the address. This shows that every field reaches the compare. It is also tried with a mismatch that follows a good instruction by one cycle, which separates a design that suppresses the write in the detect cycle from one that lets the older entry retire. Error bursts are separated by clean runs that either reach or fall short of CLEAN_RUN, so each of the three classes is produced and the counter's clearing and saturation can be seen. Corrupt inputs are fed during recovery to show that they are ignored. A long random stretch then mixes instruction streams, flush delays and clears against a cycle model.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESET,
    ST_PURGE,
    ST_RESTORE,
    ST_RETRY
  } recState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;   // retire stage may load new work
    logic ckptWr;    // commit retire stage into the checkpoint
  } dpStrobe_t;

  localparam int FAULT_W = 3;
  localparam int F_TRANS = 0;
  localparam int F_INTER = 1;
  localparam int F_PERM  = 2;

endpackage

// File: rtl/lsc_datapath.sv
module lsc_datapath
  import lsc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int NREG   = 8,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              inValid,
  input  logic [IDX_W-1:0]  aIdx,
  input  logic [DATA_W-1:0] aData,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [IDX_W-1:0]  bIdx,
  input  logic [DATA_W-1:0] bData,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              mismatch,
  output logic              retValid,
  output logic [ADDR_W-1:0] ckptAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [IDX_W-1:0]  retIdx;
  logic [DATA_W-1:0] retData;
  logic [ADDR_W-1:0] retAddr;
  logic [DATA_W-1:0] ckFile [NREG];

  // compare one stage ahead of retirement
  assign mismatch = inValid &&
                    ((aIdx != bIdx) || (aData != bData) || (aAddr != bAddr));

  // retire stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retValid <= 1'b0;
      retIdx   <= '0;
      retData  <= '0;
      retAddr  <= '0;
    end else if (stb.capture) begin
      retValid <= inValid && !mismatch;
      retIdx   <= aIdx;
      retData  <= aData;
      retAddr  <= aAddr;
    end else begin
      retValid <= 1'b0;
    end
  end

  // protected checkpoint entries, never touched by the unit reset
  for (genvar g = 0; g < NREG; g++) begin : gEntry
    logic [DATA_W-1:0] entryQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        entryQ <= '0;
      else if (stb.ckptWr && (retIdx == IDX_W'(g)))
        entryQ <= retData;
    end
    assign ckFile[g] = entryQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ckptAddr <= '0;
    else if (stb.ckptWr)
      ckptAddr <= retAddr;
  end

  assign rdData = ckFile[rdIdx];

  a_r3_no_commit_on_mismatch : assert property (@(posedge clk) disable iff (!rstN)
    stb.ckptWr |-> !mismatch);

  a_r2_commit_address : assert property (@(posedge clk) disable iff (!rstN)
    stb.ckptWr |=> (ckptAddr == $past(retAddr)));

endmodule

// File: rtl/lsc_control.sv
module lsc_control
  import lsc_pkg::*;
#(
  parameter int NREG       = 8,
  parameter int IDX_W      = $clog2(NREG),
  parameter int ERR_THRESH = 4,
  parameter int CLEAN_RUN  = 6,
  parameter int RESET_CYC  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               mismatch,
  input  logic               retValid,
  input  logic               purgeDone,
  input  logic               clrStb,
  input  logic [FAULT_W-1:0] clrMask,
  output dpStrobe_t          stb,
  output logic               busy,
  output logic               unitReset,
  output logic               purgeReq,
  output logic               restoreValid,
  output logic [IDX_W-1:0]   restoreIdx,
  output logic               retryValid,
  output logic [FAULT_W-1:0] faultStatus,
  output logic               spareReq
);

  localparam int ERR_W = $clog2(ERR_THRESH + 1);
  localparam int RUN_W = $clog2(CLEAN_RUN + 1);
  localparam int RST_W = (RESET_CYC > 1) ? $clog2(RESET_CYC) : 1;

  recState_t          state;
  logic [RST_W-1:0]   rstCnt;
  logic [IDX_W-1:0]   rIdx;
  logic [ERR_W-1:0]   errCnt, errNext;
  logic [RUN_W-1:0]   goodCnt;
  logic               isIdle, accept;
  logic [FAULT_W-1:0] classSet, clrBits;

  assign isIdle     = (state == ST_IDLE);
  assign accept     = isIdle && mismatch;
  assign stb.capture = isIdle;
  assign stb.ckptWr  = isIdle && retValid && !mismatch;

  // recovery sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rstCnt <= '0;
      rIdx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (mismatch) begin
          state  <= ST_RESET;
          rstCnt <= '0;
        end
        ST_RESET: begin
          if (rstCnt == RST_W'(RESET_CYC - 1)) state <= ST_PURGE;
          else rstCnt <= rstCnt + RST_W'(1);
        end
        ST_PURGE: if (purgeDone) begin
          state <= ST_RESTORE;
          rIdx  <= '0;
        end
        ST_RESTORE: begin
          if (rIdx == IDX_W'(NREG - 1)) state <= ST_RETRY;
          else rIdx <= rIdx + IDX_W'(1);
        end
        ST_RETRY: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // error level with saturation and clean-run clearing
  assign errNext = (errCnt == ERR_W'(ERR_THRESH)) ? errCnt : errCnt + ERR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCnt  <= '0;
      goodCnt <= '0;
    end else if (accept) begin
      errCnt  <= errNext;
      goodCnt <= '0;
    end else if (stb.ckptWr) begin
      if (goodCnt == RUN_W'(CLEAN_RUN - 1)) begin
        goodCnt <= '0;
        errCnt  <= '0;
      end else begin
        goodCnt <= goodCnt + RUN_W'(1);
      end
    end
  end

  // fault classification
  always_comb begin
    classSet = '0;
    if (accept) begin
      if (errNext == ERR_W'(ERR_THRESH))  classSet[F_PERM]  = 1'b1;
      else if (errNext == ERR_W'(1))      classSet[F_TRANS] = 1'b1;
      else                                classSet[F_INTER] = 1'b1;
    end
  end

  assign clrBits = clrStb ? clrMask : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultStatus <= '0;
    else       faultStatus <= (faultStatus & ~clrBits) | classSet;
  end

  assign busy         = !isIdle;
  assign unitReset    = (state == ST_RESET);
  assign purgeReq     = (state == ST_PURGE);
  assign restoreValid = (state == ST_RESTORE);
  assign restoreIdx   = restoreValid ? rIdx : '0;
  assign retryValid   = (state == ST_RETRY);
  assign spareReq     = faultStatus[F_PERM];

  a_r8_count_saturates : assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= ERR_W'(ERR_THRESH));

  a_r4_count_frozen_in_recovery : assert property (@(posedge clk) disable iff (!rstN)
    !isIdle |=> $stable(errCnt));

  a_r5_purge_after_reset : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PURGE && $past(state) != ST_PURGE) |-> $past(state) == ST_RESET);

  a_r6_restore_steps : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESTORE && $past(state) == ST_RESTORE) |-> rIdx == $past(rIdx) + IDX_W'(1));

  a_r7_retry_single : assert property (@(posedge clk) disable iff (!rstN)
    retryValid |=> isIdle);

  a_r10_perm_sticky : assert property (@(posedge clk) disable iff (!rstN)
    (faultStatus[F_PERM] && !(clrStb && clrMask[F_PERM])) |=> faultStatus[F_PERM]);

endmodule

// File: rtl/lockstep_retry_ctrl.sv
module lockstep_retry_ctrl
  import lsc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 16,
  parameter int NREG       = 8,
  parameter int ERR_THRESH = 4,
  parameter int CLEAN_RUN  = 6,
  parameter int RESET_CYC  = 2,
  localparam int IDX_W     = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [IDX_W-1:0]   aIdx,
  input  logic [DATA_W-1:0]  aData,
  input  logic [ADDR_W-1:0]  aAddr,
  input  logic [IDX_W-1:0]   bIdx,
  input  logic [DATA_W-1:0]  bData,
  input  logic [ADDR_W-1:0]  bAddr,
  input  logic               purgeDone,
  input  logic               clrStb,
  input  logic [FAULT_W-1:0] clrMask,
  output logic               busy,
  output logic               unitReset,
  output logic               purgeReq,
  output logic               restoreValid,
  output logic [IDX_W-1:0]   restoreIdx,
  output logic [DATA_W-1:0]  restoreData,
  output logic               retryValid,
  output logic [ADDR_W-1:0]  retryAddr,
  output logic [ADDR_W-1:0]  ckptAddr,
  output logic [FAULT_W-1:0] faultStatus,
  output logic               spareReq
);

  dpStrobe_t         stb;
  logic              mismatch, retValid;
  logic [DATA_W-1:0] rdData;

  lsc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .inValid(inValid),
    .aIdx(aIdx), .aData(aData), .aAddr(aAddr),
    .bIdx(bIdx), .bData(bData), .bAddr(bAddr),
    .rdIdx(restoreIdx), .mismatch(mismatch), .retValid(retValid),
    .ckptAddr(ckptAddr), .rdData(rdData)
  );

  lsc_control #(.NREG(NREG), .IDX_W(IDX_W), .ERR_THRESH(ERR_THRESH),
                .CLEAN_RUN(CLEAN_RUN), .RESET_CYC(RESET_CYC)) uCtl (
    .clk(clk), .rstN(rstN), .mismatch(mismatch), .retValid(retValid),
    .purgeDone(purgeDone), .clrStb(clrStb), .clrMask(clrMask), .stb(stb),
    .busy(busy), .unitReset(unitReset), .purgeReq(purgeReq),
    .restoreValid(restoreValid), .restoreIdx(restoreIdx), .retryValid(retryValid),
    .faultStatus(faultStatus), .spareReq(spareReq)
  );

  assign restoreData = restoreValid ? rdData : '0;
  assign retryAddr   = retryValid ? ckptAddr : '0;

endmodule

// File: tb/sim_lockstep_retry_ctrl.sv
`timescale 1ns/1ps
module sim_lockstep_retry_ctrl;
  localparam int DW = 16, AW = 16, NR = 8, IW = 3, TH = 4, CR = 6, RC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          inValid = 0, purgeDone = 0, clrStb = 0;
  logic [IW-1:0] aIdx = 0, bIdx = 0;
  logic [DW-1:0] aData = 0, bData = 0;
  logic [AW-1:0] aAddr = 0, bAddr = 0;
  logic [2:0]    clrMask = 0;
  logic          busy, unitReset, purgeReq, restoreValid, retryValid, spareReq;
  logic [IW-1:0] restoreIdx;
  logic [DW-1:0] restoreData;
  logic [AW-1:0] retryAddr, ckptAddr;
  logic [2:0]    faultStatus;

  lockstep_retry_ctrl #(.DATA_W(DW), .ADDR_W(AW), .NREG(NR), .ERR_THRESH(TH),
                        .CLEAN_RUN(CR), .RESET_CYC(RC)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .aIdx(aIdx), .aData(aData), .aAddr(aAddr),
    .bIdx(bIdx), .bData(bData), .bAddr(bAddr),
    .purgeDone(purgeDone), .clrStb(clrStb), .clrMask(clrMask),
    .busy(busy), .unitReset(unitReset), .purgeReq(purgeReq),
    .restoreValid(restoreValid), .restoreIdx(restoreIdx), .restoreData(restoreData),
    .retryValid(retryValid), .retryAddr(retryAddr), .ckptAddr(ckptAddr),
    .faultStatus(faultStatus), .spareReq(spareReq)
  );

  int nChk = 0, nFail = 0, cyc = 0;

  // reference model state: 0 idle, 1 reset, 2 purge, 3 restore, 4 retry
  int            mState = 0, mRstCnt = 0, mRIdx = 0, mErr = 0, mGood = 0;
  bit            mRetV = 0;
  logic [IW-1:0] mRetIdx = 0;
  logic [DW-1:0] mRetData = 0;
  logic [AW-1:0] mRetAddr = 0;
  logic [DW-1:0] mCk [NR];
  logic [AW-1:0] mPc = 0;
  logic [2:0]    mStat = 0;
  logic [AW-1:0] nextAddr = 16'h0100;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  task automatic modelUpdate();
    bit mm, idle, wr;
    logic [2:0] setM;
    int en;
    mm   = inValid && ((aIdx != bIdx) || (aData != bData) || (aAddr != bAddr));
    idle = (mState == 0);
    wr   = idle && mRetV && !mm;
    setM = 3'b000;
    if (wr) begin
      mCk[mRetIdx] = mRetData;
      mPc = mRetAddr;
      if (mGood + 1 == CR) begin mGood = 0; mErr = 0; end
      else mGood++;
    end
    if (idle && mm) begin
      en = (mErr == TH) ? TH : mErr + 1;
      mErr = en; mGood = 0;
      if (en == TH) setM = 3'b100;
      else if (en == 1) setM = 3'b001;
      else setM = 3'b010;
    end
    mStat = (mStat & ~(clrStb ? clrMask : 3'b000)) | setM;
    if (idle) begin
      mRetV = inValid && !mm;
      mRetIdx = aIdx; mRetData = aData; mRetAddr = aAddr;
    end else begin
      mRetV = 0;
    end
    case (mState)
      0: if (mm) begin mState = 1; mRstCnt = 0; end
      1: if (mRstCnt == RC - 1) mState = 2; else mRstCnt++;
      2: if (purgeDone) begin mState = 3; mRIdx = 0; end
      3: if (mRIdx == NR - 1) mState = 4; else mRIdx++;
      default: mState = 0;
    endcase
  endtask

  task automatic compareAll();
    check("R1", "busy", busy, mState != 0);
    check("R5", "unitReset", unitReset, mState == 1);
    check("R5", "purgeReq", purgeReq, mState == 2);
    check("R6", "restoreValid", restoreValid, mState == 3);
    if (mState == 3) begin
      check("R6", "restoreIdx", restoreIdx, mRIdx);
      check("R6", "restoreData", restoreData, mCk[mRIdx]);
    end
    check("R7", "retryValid", retryValid, mState == 4);
    if (mState == 4) check("R7", "retryAddr", retryAddr, mPc);
    check("R2", "ckptAddr", ckptAddr, mPc);
    check("R9", "faultStatus", faultStatus, mStat);
    check("R10", "spareReq", spareReq, mStat[2]);
  endtask

  task automatic step();
    modelUpdate();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic drive(bit v, bit bad);
    int f;
    inValid = v;
    aIdx = IW'($urandom); aData = DW'($urandom); aAddr = nextAddr;
    bIdx = aIdx; bData = aData; bAddr = aAddr;
    nextAddr = nextAddr + 16'd4;
    if (bad) begin
      f = $urandom % 3;
      if (f == 0) bData = aData ^ DW'(1 << ($urandom % DW));
      else if (f == 1) bIdx = aIdx ^ IW'(1 << ($urandom % IW));
      else bAddr = aAddr ^ AW'(1 << ($urandom % AW));
    end
  endtask

  task automatic idleIn();
    inValid = 0; purgeDone = 0; clrStb = 0; clrMask = 0;
  endtask

  task automatic good(int n);
    for (int i = 0; i < n; i++) begin drive(1, 0); step(); end
    idleIn();
  endtask

  task automatic bad();
    drive(1, 1); step(); idleIn();
  endtask

  // walk through recovery while feeding corrupt work (R4)
  task automatic recover();
    for (int i = 0; i < 80 && mState != 0; i++) begin
      drive($urandom % 2, $urandom % 2);
      purgeDone = (mState == 2) && ($urandom % 3 == 0);
      step();
    end
    idleIn();
    check("R7", "back to idle", busy, 0);
  endtask

  task automatic clr(logic [2:0] m);
    clrStb = 1; clrMask = m; step(); idleIn();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nChk++; nFail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0]    s;
    logic [AW-1:0] keep;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NR; i++) mCk[i] = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "busy", busy, 0);
    check("R12", "faultStatus", faultStatus, 0);
    check("R12", "ckptAddr", ckptAddr, 0);
    check("R12", "purgeReq", purgeReq, 0);
    check("R12", "spareReq", spareReq, 0);
    rstN = 1;
    step(); step();

    // R2: clean stream, no stall
    good(10);
    step();
    check("R2", "last retired address", ckptAddr, nextAddr - 16'd4);
    check("R1", "no stall on match", busy, 0);

    // R3: mismatch right behind a good instruction
    keep = ckptAddr;
    drive(1, 0); step();
    bad();
    check("R3", "older entry dropped", ckptAddr, keep);
    check("R9", "transient class", faultStatus, 3'b001);
    s = faultStatus;
    recover();
    check("R4", "status unchanged in recovery", faultStatus, s);
    check("R4", "ckpt unchanged in recovery", ckptAddr, keep);

    clr(3'b111);
    check("R11", "cleared", faultStatus, 3'b000);

    // R8: full clean run resets count
    good(CR); step();
    bad();
    check("R8", "count restarted", faultStatus, 3'b001);
    recover();
    clr(3'b111);

    // R8/R9: short clean run keeps count climbing
    good(2); step();
    bad();
    check("R9", "intermittent class", faultStatus, 3'b010);
    recover();
    bad();
    check("R9", "still intermittent", faultStatus, 3'b010);
    recover();
    bad();
    check("R9", "permanent at threshold", faultStatus, 3'b110);
    check("R10", "spare raised", spareReq, 1);
    recover();
    bad();
    check("R8", "saturated stays permanent", faultStatus, 3'b110);
    recover();

    // R11 / R10: selective clears
    clr(3'b010);
    check("R11", "only intermittent cleared", faultStatus, 3'b100);
    check("R10", "spare held", spareReq, 1);
    clr(3'b100);
    check("R10", "spare dropped", spareReq, 0);
    drive(1, 1); clrStb = 1; clrMask = 3'b111; step(); idleIn();
    check("R11", "set wins over clear", faultStatus, 3'b100);
    recover();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (mState == 0) drive($urandom % 10 < 7, $urandom % 25 == 0);
      else drive($urandom % 2, $urandom % 2);
      purgeDone = (mState == 2) && ($urandom % 3 == 0);
      clrStb = ($urandom % 40 == 0);
      clrMask = 3'($urandom);
      step();
    end
    idleIn();
    summary();
    $finish;
  end
endmodule